// File: doc/BRIEF.md
# LIN Slave Sleep and Wake Controller

This block decides whether a LIN slave node is asleep. It watches the bus receive level after a two-flop synchroniser, together with a single-cycle strobe from a separate frame decoder that reports each received frame's identifier and first data byte. While the node is awake, it goes to sleep for one of two reasons. The first is a go-to-sleep diagnostic frame. The second is a long stretch with no bus activity, and only when automatic sleep is enabled.

While asleep, the block arms a wake-up qualifier. The bus must go dominant, stay dominant for at least a minimum time, and then return to recessive. The block raises a one-cycle wake event on that closing rising edge and clears the sleep flag on the next cycle. All timing counts cycles of the block clock, so the bus bit rate (anywhere from 1 to 20 kbit/s) has no effect on it. The tick rate, the inactivity window in milliseconds and the minimum dominant time in microseconds are parameters. With the default 10 MHz tick they give 40,000,000 and 1,500 cycles.

The frame strobe has no ready signal. The decoder presents one frame per strobe cycle, and the block accepts it unconditionally, so there is no back-pressure. The sleep flag and wake event are plain level and pulse outputs.

Top module: `lin_sleep_ctrl`

## Requirements
- R1: After reset, `sleeping` is 0 and `wake_pulse` is 0.
- R2: While awake, a strobe carrying identifier 0x3C and first data byte 0x00 sets `sleeping` on the clock edge that ends the strobe cycle.
- R3: A strobe with identifier 0x3C and a nonzero first byte, or any other identifier, leaves the node awake.
- R4: With `auto_sleep_en` high, IDLE_CYC consecutive cycles without a bus edge or frame strobe put the node to sleep.
- R5: With `auto_sleep_en` low, the inactivity window never puts the node to sleep.
- R6: Every synchronised bus edge and every frame strobe restarts the inactivity window from zero.
- R7: Polarity is 1 = recessive and 0 = dominant. While asleep, a dominant level lasting at least WAKE_CYC cycles gives a one-cycle `wake_pulse` in the cycle where the synchronised level returns to recessive. `sleeping` clears on the next edge.
- R8: While asleep, a dominant pulse shorter than WAKE_CYC cycles produces no wake event, and the node stays asleep.
- R9: While asleep, a bus held dominant produces no wake event for as long as it stays dominant.
- R10: `wake_pulse` is only ever raised while asleep. After a wake, the inactivity window restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (TICK_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rx | input | 1 | Asynchronous bus receive level, 1 recessive, 0 dominant |
| auto_sleep_en | input | 1 | Enables sleep on inactivity |
| frm_valid | input | 1 | One-cycle strobe for a received frame |
| frm_id | input | 6 | Identifier of the strobed frame |
| frm_data0 | input | 8 | First data byte of the strobed frame |
| sleeping | output | 1 | Node is in sleep |
| wake_pulse | output | 1 | One-cycle wake event |

## Verification
The embedded assertions check the following on every cycle:
- a wake event appears only while asleep and only on a return to recessive;
- a wake event lasts one cycle and is followed by the wake state;
- a sleep frame always leads to sleep;
- sleep persists until a wake event;
- the inactivity counter stays within its window.

Other behaviour can only be shown by the bench's scenarios, because it depends on how the stimulus is shaped:
- pulse widths one cycle below and exactly at the threshold;
- a bus stuck dominant;
- frames with identifier 0x3C and a nonzero first byte;
- the exact length of the inactivity window, including its restart after a wake and its suppression by edges, strobes or the enable.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int ID_W   = 6;
  localparam int DATA_W = 8;
  localparam logic [ID_W-1:0]   SLEEP_CMD_ID   = 6'h3C;
  localparam logic [DATA_W-1:0] SLEEP_CMD_BYTE = 8'h00;

  typedef enum logic {
    WQ_IDLE = 1'b0,
    WQ_LOW  = 1'b1
  } wq_state_t;
endpackage

// File: rtl/lsw_rx_sync.sv
module lsw_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic rx_lvl,
  output logic rx_fall,
  output logic rx_rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rx_lvl  = sync_q;
  assign rx_fall = prev_q & ~sync_q;
  assign rx_rise = ~prev_q & sync_q;
endmodule

// File: rtl/lsw_idle_timer.sv
module lsw_idle_timer #(
  parameter int unsigned WINDOW = 40_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic timeout
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || !en)   cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign timeout = en & ~clr & (cnt_q == LAST);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4

  AST_TIMER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/lsw_wake_qual.sv
module lsw_wake_qual
  import lsw_pkg::*;
#(
  parameter int unsigned MIN_LOW = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic rx_lvl,
  input  logic rx_fall,
  input  logic rx_rise,
  output logic wake
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam logic [LW-1:0] SAT = LW'(MIN_LOW);

  wq_state_t st_q;
  logic [LW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WQ_IDLE;
      low_q <= '0;
    end else if (!armed) begin
      st_q  <= WQ_IDLE;
      low_q <= '0;
    end else begin
      unique case (st_q)
        WQ_IDLE: if (rx_fall) begin
          st_q  <= WQ_LOW;
          low_q <= LW'(1);
        end
        WQ_LOW: if (rx_rise) begin
          st_q  <= WQ_IDLE;
          low_q <= '0;
        end else if (low_q != SAT) begin
          low_q <= low_q + 1'b1;
        end
        default: st_q <= WQ_IDLE;
      endcase
    end
  end

  assign wake = armed & (st_q == WQ_LOW) & rx_rise & (low_q >= SAT);

  AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (rx_lvl && !$past(rx_lvl))); // R7
endmodule

// File: rtl/lin_sleep_ctrl.sv
module lin_sleep_ctrl
  import lsw_pkg::*;
#(
  parameter int unsigned TICK_HZ = 10_000_000,
  parameter int unsigned IDLE_MS = 4000,
  parameter int unsigned WAKE_US = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rx,
  input  logic              auto_sleep_en,
  input  logic              frm_valid,
  input  logic [ID_W-1:0]   frm_id,
  input  logic [DATA_W-1:0] frm_data0,
  output logic              sleeping,
  output logic              wake_pulse
);
  localparam longint unsigned IDLE_L =
    longint'(TICK_HZ) * longint'(IDLE_MS) / 64'd1000;
  localparam longint unsigned WAKE_L =
    longint'(TICK_HZ) * longint'(WAKE_US) / 64'd1000000;
  localparam int unsigned IDLE_CYC = (IDLE_L < 2) ? 2 : int'(IDLE_L);
  localparam int unsigned WAKE_CYC = (WAKE_L < 1) ? 1 : int'(WAKE_L);

  logic rx_lvl, rx_fall, rx_rise;
  logic timeout, timer_clr, sleep_cmd, wake;
  logic sleep_q;

  lsw_rx_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_async (bus_rx),
    .rx_lvl   (rx_lvl),
    .rx_fall  (rx_fall),
    .rx_rise  (rx_rise)
  );

  assign timer_clr = sleep_q | rx_fall | rx_rise | frm_valid;

  lsw_idle_timer #(.WINDOW(IDLE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (timer_clr),
    .en      (auto_sleep_en),
    .timeout (timeout)
  );

  lsw_wake_qual #(.MIN_LOW(WAKE_CYC)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (sleep_q),
    .rx_lvl  (rx_lvl),
    .rx_fall (rx_fall),
    .rx_rise (rx_rise),
    .wake    (wake)
  );

  assign sleep_cmd = frm_valid & (frm_id == SLEEP_CMD_ID) &
                     (frm_data0 == SLEEP_CMD_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sleep_q <= 1'b0;
    else if (sleep_q && wake)            sleep_q <= 1'b0;
    else if (!sleep_q && (sleep_cmd || timeout)) sleep_q <= 1'b1;
  end

  assign sleeping   = sleep_q;
  assign wake_pulse = wake;

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> sleeping); // R10

  AST_WAKE_CLEARS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !sleeping); // R7

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R7

  AST_SLEEP_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_id == 6'h3C && frm_data0 == 8'h00) |=> sleeping); // R2

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !wake_pulse) |=> sleeping); // R8
endmodule

// File: tb/lin_sleep_ctrl_test.sv
module lin_sleep_ctrl_test;
  localparam int unsigned HZ   = 100_000;
  localparam int unsigned MS   = 20;
  localparam int unsigned US   = 150;
  localparam int IDLE = 2000;  // HZ*MS/1000
  localparam int WK   = 15;    // HZ*US/1e6

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rx = 1'b1;
  logic auto_sleep_en = 1'b1;
  logic frm_valid = 1'b0;
  logic [5:0] frm_id = '0;
  logic [7:0] frm_data0 = '0;
  logic sleeping, wake_pulse;

  always #5 clk = ~clk;

  lin_sleep_ctrl #(.TICK_HZ(HZ), .IDLE_MS(MS), .WAKE_US(US)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rx(bus_rx), .auto_sleep_en(auto_sleep_en),
    .frm_valid(frm_valid), .frm_id(frm_id), .frm_data0(frm_data0),
    .sleeping(sleeping), .wake_pulse(wake_pulse)
  );

  typedef struct {
    bit    sl;
    int    wk;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int checks = 0, errors = 0, wake_seen = 0, wake_base = 0;
  bit done = 1'b0;

  // monitor: counts wake events, pops expected items, compares
  always @(negedge clk) begin
    if (wake_pulse) wake_seen++;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      checks++;
      if (sleeping !== cur.sl || (wake_seen - wake_base) != cur.wk) begin
        errors++;
        $display("FAIL %s: sleeping=%0b wakes=%0d, expected sleeping=%0b wakes=%0d",
                 cur.tag, sleeping, wake_seen - wake_base, cur.sl, cur.wk);
      end
      wake_base = wake_seen;
    end
  end

  task automatic expect_state(input bit sl, input int wk, input string tag);
    sb.push_back('{sl, wk, tag});
    repeat (2) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dominant(input int n);
    bus_rx = 1'b0;
    repeat (n) @(negedge clk);
    bus_rx = 1'b1;
  endtask

  task automatic send_frame(input logic [5:0] id, input logic [7:0] d0);
    frm_valid = 1'b1; frm_id = id; frm_data0 = d0;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    idle(3);
    chk("R1 sleeping in reset", int'(sleeping), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 wake_pulse after reset", int'(wake_pulse), 0);
    expect_state(1'b0, 0, "R1 reset state");

    // R3: near-miss frames
    send_frame(6'h3C, 8'h05);
    chk("R3 0x3C nonzero byte", int'(sleeping), 0);
    send_frame(6'h3D, 8'h00);
    chk("R3 other id", int'(sleeping), 0);
    expect_state(1'b0, 0, "R3 no sleep on near-miss frames");

    // R2: sleep command takes effect at the strobe's closing edge
    send_frame(6'h3C, 8'h00);
    chk("R2 sleep after strobe", int'(sleeping), 1);
    expect_state(1'b1, 0, "R2 asleep");

    // R8: one cycle short
    dominant(WK - 1);
    idle(6);
    expect_state(1'b1, 0, "R8 short pulse ignored");

    // R7: exactly the threshold
    dominant(WK);
    @(negedge clk);
    chk("R7 no wake before sync", int'(wake_pulse), 0);
    @(negedge clk);
    chk("R7 wake on release", int'(wake_pulse), 1);
    chk("R7 still asleep in wake cycle", int'(sleeping), 1);
    @(negedge clk);
    chk("R7 pulse one cycle", int'(wake_pulse), 0);
    chk("R7 awake after wake", int'(sleeping), 0);
    expect_state(1'b0, 1, "R7 one wake event");

    // R10 + R4: window restarts after wake
    idle(IDLE - 100);
    expect_state(1'b0, 0, "R10 awake before full window");
    idle(150);
    expect_state(1'b1, 0, "R4 timeout sleep");

    // R9: stuck dominant
    bus_rx = 1'b0;
    idle(3000);
    expect_state(1'b1, 0, "R9 stuck dominant no wake");
    bus_rx = 1'b1;
    idle(5);
    expect_state(1'b0, 1, "R7 release after long dominant");

    // R10: long pulse while awake gives no wake event
    dominant(40);
    idle(5);
    expect_state(1'b0, 0, "R10 no wake while awake");

    // R6: edges and strobes keep the node awake
    for (int i = 0; i < 3; i++) begin
      idle(IDLE - 400);
      dominant(3);
    end
    idle(IDLE - 400);
    send_frame(6'h12, 8'hAA);
    idle(IDLE - 400);
    expect_state(1'b0, 0, "R6 activity restarts window");
    idle(500);
    expect_state(1'b1, 0, "R4 sleep after quiet");

    dominant(20);
    idle(5);
    expect_state(1'b0, 1, "R7 wake with longer pulse");

    // R5: auto sleep disabled
    auto_sleep_en = 1'b0;
    idle(3 * IDLE);
    expect_state(1'b0, 0, "R5 no timeout when disabled");
    auto_sleep_en = 1'b1;
    idle(IDLE + 50);
    expect_state(1'b1, 0, "R4 timeout after re-enable");

    idle(3);
    done = 1'b1;
    finish_run();
  end
endmodule